// File: doc/BRIEF.md
# Banked Memory Window Mapper

This block sits between an 8-bit processor's 16-bit address bus and a paged memory system. It cuts the 64 KB address space into four 16 KB windows, selected by the top two address bits, and points each window at one of thirty-two 16 KB RAM banks or at one of two 16 KB ROM images. An 8-bit configuration register, loaded by the processor over a plain write strobe, picks the mapping: a boot bit forces ROM everywhere, a base field picks a group of four consecutive RAM banks, a mirror flag copies the upper two windows onto the lower two, and a ROM-off bit removes a combined ROM image from the top window.

Memory traffic uses a request stream and a read-response stream, both valid/ready. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is high whenever the one-entry response slot is empty or is being emptied in the same cycle, so a stalled `rsp_ready` holds back new requests. A read returns one response on the cycle after it is taken, and that response stays unchanged until `rsp_ready` takes it. Writes return no response. The translated bank, offset, ROM select and effective write enable are given out combinationally for the request currently presented. The block contains a small behavioural memory: ROM bytes are computed from the offset, and RAM keeps only the low `MODEL_OFS_W` offset bits of each bank, so offsets that differ only above those bits alias to the same byte.

Top module: `banked_window_mapper`

## Requirements
- R1: After reset the configuration register reads 0x20 (boot bit, bit 5, set), and every window reports `map_rom`=1 with `map_bank`=0.
- R2: While configuration bit 5 is set, every address maps to ROM image 0 (`map_rom`=1, `map_bank`=0), whatever bits 4..0 hold.
- R3: With bit 5 clear, bit 0 clear and bit 4 set, window w (address bits 15:14) maps to RAM bank 4*cfg[3:1]+w with `map_rom`=0.
- R4: With bit 5 clear and bit 0 set, window 0 takes bank base+2 and window 1 takes bank base+3; this copy happens before the ROM overlay, so window 1 keeps RAM bank base+3 even when window 3 is overlaid.
- R5: With bit 5 clear and bit 4 clear, window 3 maps to ROM image 1 (`map_rom`=1, `map_bank`=1), overriding both the base mapping and the mirror.
- R6: `map_ofs` always equals address bits 13:0.
- R7: ROM image 0 returns mon(k) at every offset; ROM image 1 returns os(k) when offset bit 13 is 0 and mon(k) when it is 1, where k is offset bits 12:0, mon(k)=k[7:0] XOR 0xA5 and os(k)=k[7:0] XOR 0xC3.
- R8: After reset every RAM byte reads 0x3F.
- R9: A write to a window mapped to ROM keeps `map_we` low and leaves the data read there unchanged; a write to RAM raises `map_we` and is read back afterwards.
- R10: A configuration write governs requests taken from the next clock edge on; a request taken on the same edge as the configuration write still uses the old mapping.
- R11: Configuration bits 7 and 6 read back as written but never change the mapping.
- R12: A read taken on one edge shows `rsp_valid`=1 after that edge; while `rsp_ready` is low the response data stays fixed and `req_ready` is low.
- R13: A taken write produces no response: `rsp_valid` is low after its edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration register write strobe |
| cfg_wdata | input | 8 | Configuration value to store |
| cfg_value | output | 8 | Current configuration register contents |
| req_valid | input | 1 | Memory request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_we | input | 1 | 1 = write request, 0 = read request |
| req_addr | input | 16 | Processor address |
| req_wdata | input | 8 | Write data |
| rsp_valid | output | 1 | Read response present |
| rsp_ready | input | 1 | Consumer takes the read response |
| rsp_data | output | 8 | Read data |
| map_bank | output | BANK_W | Physical RAM bank, or ROM image index when map_rom is 1 |
| map_ofs | output | 14 | Offset within the 16 KB bank |
| map_rom | output | 1 | 1 = ROM selected, 0 = RAM selected |
| map_we | output | 1 | Effective RAM write enable for the request taken this cycle |

## Verification
The bench builds the block with `MODEL_OFS_W`=3, so each RAM bank keeps only eight bytes and the 32-bank model holds 256 bytes. With such a small store, random writes land on the same cells again and again across all banks, so read-after-write, aliasing and ROM-protected writes are hit densely within a few hundred requests, while the full 14-bit offset still reaches the ROM halves selected by offset bit 13. `BANK_W` stays at 5 so all eight base groups of the mapping are covered.

// File: rtl/bmm_pkg.sv
package bmm_pkg;
  localparam int CFG_W        = 8;
  localparam int ADDR_W       = 16;
  localparam int OFS_W        = 14;
  localparam int WIN_COUNT    = 4;
  localparam int CFG_MIRROR   = 0;
  localparam int CFG_BASE_LSB = 1;
  localparam int CFG_BASE_MSB = 3;
  localparam int CFG_ROMOFF   = 4;
  localparam int CFG_BOOT     = 5;
  localparam logic [7:0] MON_KEY = 8'hA5;
  localparam logic [7:0] OS_KEY  = 8'hC3;
  localparam logic [7:0] RAM_FILL = 8'h3F;
endpackage

// File: rtl/bmm_cfg_reg.sv
module bmm_cfg_reg
  import bmm_pkg::*;
#(
  parameter logic [CFG_W-1:0] RST_CFG = 8'h20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [CFG_W-1:0] wr_data,
  output logic [CFG_W-1:0] cfg_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= RST_CFG;
    else if (wr_en) cfg_q <= wr_data;
  end

  assert_cfg_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(cfg_q));
  assert_cfg_load_R11: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> cfg_q == $past(wr_data));
endmodule

// File: rtl/bmm_window_map.sv
module bmm_window_map
  import bmm_pkg::*;
#(
  parameter int BANK_W = 5
) (
  input  logic [CFG_W-1:0]  cfg,
  input  logic [1:0]        win,
  output logic              sel_rom,
  output logic [BANK_W-1:0] sel_bank
);
  logic [BANK_W-1:0] base;
  logic [BANK_W-1:0] raw_bank  [WIN_COUNT];
  logic [BANK_W-1:0] mir_bank  [WIN_COUNT];
  logic [BANK_W-1:0] fin_bank  [WIN_COUNT];
  logic              fin_rom   [WIN_COUNT];

  assign base = BANK_W'({cfg[CFG_BASE_MSB:CFG_BASE_LSB], 2'b00});

  for (genvar w = 0; w < WIN_COUNT; w++) begin : g_win
    localparam int SRC = (w < 2) ? w + 2 : w;
    assign raw_bank[w] = base + BANK_W'(w);
    // mirror step: lower windows copy upper windows, before the overlay
    assign mir_bank[w] = (cfg[CFG_MIRROR] && (w < 2)) ? raw_bank[SRC] : raw_bank[w];
    if (w == WIN_COUNT - 1) begin : g_top
      always_comb begin
        if (cfg[CFG_BOOT]) begin
          fin_rom[w]  = 1'b1;
          fin_bank[w] = '0;
        end else if (!cfg[CFG_ROMOFF]) begin
          fin_rom[w]  = 1'b1;
          fin_bank[w] = BANK_W'(1);
        end else begin
          fin_rom[w]  = 1'b0;
          fin_bank[w] = mir_bank[w];
        end
      end
    end else begin : g_low
      always_comb begin
        fin_rom[w]  = cfg[CFG_BOOT];
        fin_bank[w] = cfg[CFG_BOOT] ? '0 : mir_bank[w];
      end
    end
  end

  assign sel_rom  = fin_rom[win];
  assign sel_bank = fin_bank[win];
endmodule

// File: rtl/bmm_mem_model.sv
module bmm_mem_model
  import bmm_pkg::*;
#(
  parameter int BANK_W      = 5,
  parameter int MODEL_OFS_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic              rom,
  input  logic [BANK_W-1:0] bank,
  input  logic [OFS_W-1:0]  ofs,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata
);
  localparam int DEPTH = (1 << BANK_W) * (1 << MODEL_OFS_W);
  localparam int IDX_W = BANK_W + MODEL_OFS_W;

  logic [7:0]       ram [DEPTH];
  logic [IDX_W-1:0] idx;
  logic [7:0]       rom_byte;
  logic [7:0]       mon_byte;
  logic [7:0]       os_byte;

  assign idx      = {bank, ofs[MODEL_OFS_W-1:0]};
  assign mon_byte = ofs[7:0] ^ MON_KEY;
  assign os_byte  = ofs[7:0] ^ OS_KEY;
  // image 1 carries the OS in its lower half; both images carry the monitor above
  assign rom_byte = (bank[0] && !ofs[OFS_W-1]) ? os_byte : mon_byte;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) ram[i] <= RAM_FILL;
    end else if (wr_en && !rom) begin
      ram[idx] <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata <= '0;
    else if (rd_en) rdata <= rom ? rom_byte : ram[idx];
  end
endmodule

// File: rtl/banked_window_mapper.sv
module banked_window_mapper
  import bmm_pkg::*;
#(
  parameter int BANK_W      = 5,
  parameter int MODEL_OFS_W = 4,
  parameter logic [CFG_W-1:0] RST_CFG = 8'h20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [CFG_W-1:0]  cfg_wdata,
  output logic [CFG_W-1:0]  cfg_value,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_we,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [7:0]        req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [7:0]        rsp_data,
  output logic [BANK_W-1:0] map_bank,
  output logic [OFS_W-1:0]  map_ofs,
  output logic              map_rom,
  output logic              map_we
);
  logic accept;
  logic rd_en;

  bmm_cfg_reg #(.RST_CFG(RST_CFG)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_we), .wr_data(cfg_wdata), .cfg_q(cfg_value)
  );

  bmm_window_map #(.BANK_W(BANK_W)) u_map (
    .cfg(cfg_value), .win(req_addr[ADDR_W-1:ADDR_W-2]),
    .sel_rom(map_rom), .sel_bank(map_bank)
  );

  assign map_ofs   = req_addr[OFS_W-1:0];
  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;
  assign map_we    = accept && req_we && !map_rom;
  assign rd_en     = accept && !req_we;

  bmm_mem_model #(.BANK_W(BANK_W), .MODEL_OFS_W(MODEL_OFS_W)) u_mem (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .wr_en(map_we), .rom(map_rom),
    .bank(map_bank), .ofs(map_ofs), .wdata(req_wdata), .rdata(rsp_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsp_valid <= 1'b0;
    else if (rd_en) rsp_valid <= 1'b1;
    else if (rsp_ready) rsp_valid <= 1'b0;
  end

  assert_boot_rom_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_value[CFG_BOOT] |-> (map_rom && map_bank == '0));
  assert_top_overlay_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_value[CFG_BOOT] && !cfg_value[CFG_ROMOFF] && req_addr[ADDR_W-1:ADDR_W-2] == 2'd3)
      |-> (map_rom && map_bank == BANK_W'(1)));
  assert_rom_no_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    map_rom |-> !map_we);
  assert_rsp_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data)));
  assert_backpressure_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> !req_ready);
  assert_read_rsp_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !req_we) |=> rsp_valid);
  assert_write_silent_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_we) |=> !rsp_valid);
endmodule

// File: tb/test_banked_window_mapper.sv
module test_banked_window_mapper;
  localparam int MOW = 3;
  localparam int BW  = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [7:0] cfg_wdata = '0;
  logic [7:0] cfg_value;
  logic req_valid = 1'b0;
  logic req_ready;
  logic req_we = 1'b0;
  logic [15:0] req_addr = '0;
  logic [7:0] req_wdata = '0;
  logic rsp_valid;
  logic rsp_ready = 1'b1;
  logic [7:0] rsp_data;
  logic [BW-1:0] map_bank;
  logic [13:0] map_ofs;
  logic map_rom;
  logic map_we;

  int checks = 0;
  int fails = 0;
  logic [7:0] sh_cfg;
  logic [7:0] sh_ram [(1 << BW) * (1 << MOW)];

  always #4 clk = ~clk;

  banked_window_mapper #(.BANK_W(BW), .MODEL_OFS_W(MOW)) i_banked_window_mapper (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_value(cfg_value),
    .req_valid(req_valid), .req_ready(req_ready), .req_we(req_we), .req_addr(req_addr),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .map_bank(map_bank), .map_ofs(map_ofs), .map_rom(map_rom), .map_we(map_we)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // expected {rom, bank} from the requirements
  function automatic logic [BW:0] exp_map(input logic [7:0] c, input logic [15:0] a);
    int w;
    int b;
    w = int'(a[15:14]);
    if (c[5]) return {1'b1, BW'(0)};
    if (w == 3 && !c[4]) return {1'b1, BW'(1)};
    b = 4 * int'(c[3:1]) + w;
    if (c[0] && w < 2) b = b + 2;
    return {1'b0, BW'(b)};
  endfunction

  function automatic logic [7:0] rom_val(input logic img, input logic [13:0] o);
    if (img && !o[13]) return o[7:0] ^ 8'hC3;
    return o[7:0] ^ 8'hA5;
  endfunction

  function automatic int ram_idx(input logic [BW-1:0] b, input logic [13:0] o);
    return int'(b) * (1 << MOW) + int'(o[MOW-1:0]);
  endfunction

  function automatic logic [7:0] exp_data(input logic [15:0] a);
    logic [BW:0] m;
    m = exp_map(sh_cfg, a);
    if (m[BW]) return rom_val(m[0], a[13:0]);
    return sh_ram[ram_idx(m[BW-1:0], a[13:0])];
  endfunction

  task automatic set_cfg(input logic [7:0] v);
    @(negedge clk);
    cfg_we = 1'b1;
    cfg_wdata = v;
    @(posedge clk);
    @(negedge clk);
    cfg_we = 1'b0;
    sh_cfg = v;
  endtask

  task automatic check_map(input string tag, input logic [15:0] a);
    logic [BW:0] m;
    m = exp_map(sh_cfg, a);
    chk({tag, " rom"}, 32'(map_rom), 32'(m[BW]));
    chk({tag, " bank"}, 32'(map_bank), 32'(m[BW-1:0]));
    chk("R6 offset", 32'(map_ofs), 32'(a[13:0]));
  endtask

  task automatic do_read(input string tag, input logic [15:0] a);
    logic [7:0] e;
    @(negedge clk);
    req_valid = 1'b1;
    req_we = 1'b0;
    req_addr = a;
    #1;
    check_map(tag, a);
    e = exp_data(a);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk("R12 rsp_valid", 32'(rsp_valid), 32'd1);
    chk({tag, " data"}, 32'(rsp_data), 32'(e));
  endtask

  task automatic do_write(input string tag, input logic [15:0] a, input logic [7:0] d);
    logic [BW:0] m;
    m = exp_map(sh_cfg, a);
    @(negedge clk);
    req_valid = 1'b1;
    req_we = 1'b1;
    req_addr = a;
    req_wdata = d;
    #1;
    check_map(tag, a);
    chk("R9 map_we", 32'(map_we), 32'(!m[BW]));
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    req_we = 1'b0;
    chk("R13 no response", 32'(rsp_valid), 32'd0);
    if (!m[BW]) sh_ram[ram_idx(m[BW-1:0], a[13:0])] = d;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%h expected=%h", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin : main
    void'($urandom(32'd20240611));
    for (int i = 0; i < (1 << BW) * (1 << MOW); i++) sh_ram[i] = 8'h3F;
    sh_cfg = 8'h20;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    chk("R1 cfg reset", 32'(cfg_value), 32'h20);
    for (int w = 0; w < 4; w++) begin
      req_addr = 16'(w << 14);
      #1;
      chk("R1 rom", 32'(map_rom), 32'd1);
      chk("R1 bank", 32'(map_bank), 32'd0);
    end
    chk("R12 idle rsp", 32'(rsp_valid), 32'd0);
    // R2 boot bit dominates, R7 image 0 both halves
    set_cfg(8'h3F);
    do_read("R2 boot ROM lo", 16'h0123);
    do_read("R7 image0 hi half", 16'h6123);
    do_write("R9 write ROM", 16'h4010, 8'h55);
    do_read("R9 ROM unchanged", 16'h4010);
    // R8 power-up fill, R3 base mapping
    set_cfg(8'h10);
    do_read("R8 fill bank0", 16'h0002);
    do_read("R8 fill bank3", 16'hC007);
    set_cfg(8'h1A);
    for (int w = 0; w < 4; w++) do_write("R3 base", 16'(w << 14) | 16'h0005, 8'(8'h80 + w));
    for (int w = 0; w < 4; w++) do_read("R3 base readback", 16'(w << 14) | 16'h0005);
    // R4 mirror, R5 overlay after mirror
    set_cfg(8'h1B);
    do_read("R4 mirror w0", 16'h0005);
    do_read("R4 mirror w1", 16'h4005);
    set_cfg(8'h0B);
    do_read("R4 mirror w1 keeps RAM", 16'h4005);
    do_read("R5 overlay os half", 16'hC123);
    do_read("R7 image1 monitor half", 16'hE123);
    do_write("R9 write overlay", 16'hC123, 8'h11);
    do_read("R9 overlay unchanged", 16'hC123);
    // R11 upper bits stored, ignored
    set_cfg(8'hDA);
    chk("R11 readback", 32'(cfg_value), 32'hDA);
    do_read("R11 same as 0x1A", 16'h8005);
    // R10 same-edge config write uses old mapping
    set_cfg(8'h10);
    do_write("R10 prep", 16'hC005, 8'h77);
    @(negedge clk);
    cfg_we = 1'b1;
    cfg_wdata = 8'h00;
    req_valid = 1'b1;
    req_we = 1'b0;
    req_addr = 16'hC005;
    @(posedge clk);
    @(negedge clk);
    cfg_we = 1'b0;
    req_valid = 1'b0;
    chk("R10 old mapping", 32'(rsp_data), 32'h77);
    sh_cfg = 8'h00;
    do_read("R10 new mapping", 16'hC005);
    // R12 back-pressure
    set_cfg(8'h10);
    @(negedge clk);
    rsp_ready = 1'b0;
    req_valid = 1'b1;
    req_addr = 16'hC005;
    @(posedge clk);
    @(negedge clk);
    req_addr = 16'h0002;
    chk("R12 valid held", 32'(rsp_valid), 32'd1);
    chk("R12 ready low", 32'(req_ready), 32'd0);
    chk("R12 data", 32'(rsp_data), 32'h77);
    @(posedge clk);
    @(negedge clk);
    chk("R12 data stable", 32'(rsp_data), 32'h77);
    rsp_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk("R12 second valid", 32'(rsp_valid), 32'd1);
    chk("R12 second data", 32'(rsp_data), 32'(exp_data(16'h0002)));
    // random mix
    for (int n = 0; n < 400; n++) begin
      logic [31:0] r;
      logic [15:0] a;
      r = $urandom;
      a = 16'($urandom);
      if (r[3:0] == 4'd0) set_cfg(8'($urandom));
      else if (r[4]) do_write("R9 random write", a, 8'($urandom));
      else do_read("R7 random read", a);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule